// File: doc/BRIEF.md
# Two-Object Correlation Trigger Condition

This block evaluates one trigger condition per bunch crossing over four calorimeter candidate objects. Each candidate carries a transverse energy, a signed pseudorapidity index, an azimuth index and an isolation flag. The condition fires when one object passes the first leg's cuts, a different object passes the second leg's cuts, and the pair's separations in pseudorapidity and azimuth both lie inside programmed ranges. Every ordered assignment of the two legs to distinct objects is tested in parallel.

A second, independent output compares the missing transverse energy against its own threshold. All cut values arrive as static configuration inputs, normally driven from a register bank. Both outputs leave a two-stage pipeline, so the latency is the same for every input pattern and a new crossing can be presented on every clock.

Top module: `pair_corr_cond`

## Requirements
- R1: `met_hit_o` is 1 exactly when `met_i >= met_thr_i` (unsigned), as presented two clock edges earlier.
- R2: An object passes a leg when its energy is nonzero and at least that leg's threshold, its eta (two's complement) lies in the leg's inclusive signed window, its phi lies in the leg's inclusive unsigned window, and it is isolated whenever the leg's isolation-required bit is 1.
- R3: The two legs must be satisfied by two different objects; one object passing both legs alone never fires `pair_hit_o`.
- R4: Either object of a pair may serve as leg 1; all twelve ordered pairs of distinct indices are tested.
- R5: The pair's |eta_a - eta_b| must lie in the inclusive range `deta_min_i` to `deta_max_i`.
- R6: The pair's azimuthal distance is the shorter way round a ring of 72 bins (|phi_a - phi_b|, replaced by 72 minus it when above 36), and must lie in the inclusive range `dphi_min_i` to `dphi_max_i`.
- R7: Both outputs reflect the inputs (objects and configuration) present two rising edges earlier; a new crossing is accepted on every cycle.
- R8: While `rst_n` is low both outputs are 0, and they stay 0 for the first two rising edges after release.
- R9: An object with zero energy never passes a leg, even with a threshold of 0.
- R10: Object k occupies bits [k*W +: W] of each packed object bus, with W = 10 for energy, 6 for eta and 7 for phi, and bit k of `obj_iso_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| obj_et_i | input | 40 | Packed energies of four objects |
| obj_eta_i | input | 24 | Packed signed eta indices |
| obj_phi_i | input | 28 | Packed phi indices, 0 to 71 |
| obj_iso_i | input | 4 | Isolation flags, one per object |
| met_i | input | 12 | Missing transverse energy |
| met_thr_i | input | 12 | Missing-energy threshold |
| l1_thr_i | input | 10 | Leg 1 energy threshold |
| l1_eta_lo_i | input | 6 | Leg 1 eta window low edge (signed) |
| l1_eta_hi_i | input | 6 | Leg 1 eta window high edge (signed) |
| l1_phi_lo_i | input | 7 | Leg 1 phi window low edge |
| l1_phi_hi_i | input | 7 | Leg 1 phi window high edge |
| l1_iso_req_i | input | 1 | Leg 1 requires isolation |
| l2_thr_i | input | 10 | Leg 2 energy threshold |
| l2_eta_lo_i | input | 6 | Leg 2 eta window low edge (signed) |
| l2_eta_hi_i | input | 6 | Leg 2 eta window high edge (signed) |
| l2_phi_lo_i | input | 7 | Leg 2 phi window low edge |
| l2_phi_hi_i | input | 7 | Leg 2 phi window high edge |
| l2_iso_req_i | input | 1 | Leg 2 requires isolation |
| deta_min_i | input | 7 | Minimum eta separation |
| deta_max_i | input | 7 | Maximum eta separation |
| dphi_min_i | input | 7 | Minimum azimuthal separation |
| dphi_max_i | input | 7 | Maximum azimuthal separation |
| pair_hit_o | output | 1 | Correlation condition result |
| met_hit_o | output | 1 | Missing-energy condition result |

## Verification
The assertions watch, on every cycle, the missing-energy comparison against inputs two edges back, the quiet outputs right after reset, and the rule that a crossing with fewer than two nonzero objects can never fire the pair output. Which objects pass which leg, the wrap-around of the azimuthal distance, the ordered-pair search and the isolation requirement depend on the cut values in combination, so only the bench's streaming sweep against its arithmetic model, plus directed crossings at each boundary, can show them.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    parameter int ET_W   = 10;
    parameter int ETA_W  = 6;
    parameter int PHI_W  = 7;
    parameter int MET_W  = 12;
    localparam int DETA_W = ETA_W + 1;

    typedef struct packed {
        logic [ET_W-1:0]         et;
        logic signed [ETA_W-1:0] eta;
        logic [PHI_W-1:0]        phi;
        logic                    iso;
    } obj_t;

    typedef struct packed {
        logic [ET_W-1:0]         thr;
        logic signed [ETA_W-1:0] eta_lo;
        logic signed [ETA_W-1:0] eta_hi;
        logic [PHI_W-1:0]        phi_lo;
        logic [PHI_W-1:0]        phi_hi;
        logic                    iso_req;
    } leg_cfg_t;

    typedef struct packed {
        logic [DETA_W-1:0] deta_min;
        logic [DETA_W-1:0] deta_max;
        logic [PHI_W-1:0]  dphi_min;
        logic [PHI_W-1:0]  dphi_max;
    } corr_cfg_t;

endpackage

// File: rtl/pcc_leg_sel.sv
module pcc_leg_sel
    import pcc_pkg::*;
(
    input  obj_t     obj,
    input  leg_cfg_t cfg,
    output logic     pass
);
    logic signed [ETA_W-1:0] eta_v;
    logic signed [ETA_W-1:0] lo_v;
    logic signed [ETA_W-1:0] hi_v;
    logic                    e_ok;
    logic                    eta_ok;
    logic                    phi_ok;
    logic                    iso_ok;

    always_comb begin
        eta_v  = obj.eta;
        lo_v   = cfg.eta_lo;
        hi_v   = cfg.eta_hi;
        // empty slot (zero energy) is rejected before the threshold test
        e_ok   = (obj.et != '0) && (obj.et >= cfg.thr);
        eta_ok = (eta_v >= lo_v) && (eta_v <= hi_v);
        phi_ok = (obj.phi >= cfg.phi_lo) && (obj.phi <= cfg.phi_hi);
        iso_ok = obj.iso || !cfg.iso_req;
        pass   = e_ok && eta_ok && phi_ok && iso_ok;
    end
endmodule

// File: rtl/pcc_pair_geom.sv
module pcc_pair_geom
    import pcc_pkg::*;
#(
    parameter int PHI_BINS = 72
) (
    input  obj_t      obj_a,
    input  obj_t      obj_b,
    input  corr_cfg_t cfg,
    output logic      ok
);
    localparam logic [PHI_W-1:0] HALF = PHI_W'(PHI_BINS / 2);
    localparam logic [PHI_W-1:0] FULL = PHI_W'(PHI_BINS);

    logic signed [ETA_W+1:0] ea;
    logic signed [ETA_W+1:0] eb;
    logic signed [ETA_W+1:0] ediff;
    logic [DETA_W-1:0]       deta;
    logic [PHI_W-1:0]        draw;
    logic [PHI_W-1:0]        dphi;

    always_comb begin
        ea    = {{2{obj_a.eta[ETA_W-1]}}, obj_a.eta};
        eb    = {{2{obj_b.eta[ETA_W-1]}}, obj_b.eta};
        ediff = ea - eb;
        deta  = ediff[ETA_W+1] ? DETA_W'(-ediff) : DETA_W'(ediff);

        draw  = (obj_a.phi >= obj_b.phi) ? (obj_a.phi - obj_b.phi)
                                         : (obj_b.phi - obj_a.phi);
        // shorter way round the azimuth ring
        dphi  = (draw > HALF) ? (FULL - draw) : draw;

        ok = (deta >= cfg.deta_min) && (deta <= cfg.deta_max) &&
             (dphi >= cfg.dphi_min) && (dphi <= cfg.dphi_max);
    end
endmodule

// File: rtl/pair_corr_cond.sv
module pair_corr_cond
    import pcc_pkg::*;
#(
    parameter int N_OBJ    = 4,
    parameter int PHI_BINS = 72
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_OBJ*ET_W-1:0]    obj_et_i,
    input  logic [N_OBJ*ETA_W-1:0]   obj_eta_i,
    input  logic [N_OBJ*PHI_W-1:0]   obj_phi_i,
    input  logic [N_OBJ-1:0]         obj_iso_i,
    input  logic [MET_W-1:0]         met_i,
    input  logic [MET_W-1:0]         met_thr_i,
    input  logic [ET_W-1:0]          l1_thr_i,
    input  logic [ETA_W-1:0]         l1_eta_lo_i,
    input  logic [ETA_W-1:0]         l1_eta_hi_i,
    input  logic [PHI_W-1:0]         l1_phi_lo_i,
    input  logic [PHI_W-1:0]         l1_phi_hi_i,
    input  logic                     l1_iso_req_i,
    input  logic [ET_W-1:0]          l2_thr_i,
    input  logic [ETA_W-1:0]         l2_eta_lo_i,
    input  logic [ETA_W-1:0]         l2_eta_hi_i,
    input  logic [PHI_W-1:0]         l2_phi_lo_i,
    input  logic [PHI_W-1:0]         l2_phi_hi_i,
    input  logic                     l2_iso_req_i,
    input  logic [DETA_W-1:0]        deta_min_i,
    input  logic [DETA_W-1:0]        deta_max_i,
    input  logic [PHI_W-1:0]         dphi_min_i,
    input  logic [PHI_W-1:0]         dphi_max_i,
    output logic                     pair_hit_o,
    output logic                     met_hit_o
);
    localparam int NPAIR = N_OBJ * N_OBJ;

    typedef struct packed {
        logic [N_OBJ-1:0] leg1;
        logic [N_OBJ-1:0] leg2;
        logic [NPAIR-1:0] geo;
        logic             met_s1;
        logic             pair;
        logic             met;
    } pipe_t;

    obj_t             objs [N_OBJ];
    leg_cfg_t         cfg_l1;
    leg_cfg_t         cfg_l2;
    corr_cfg_t        cfg_corr;
    logic [N_OBJ-1:0] pass_l1;
    logic [N_OBJ-1:0] pass_l2;
    logic [NPAIR-1:0] geo_ok;
    pipe_t            st_d;
    pipe_t            st_q;

    // unpack buses and configuration
    always_comb begin
        for (int k = 0; k < N_OBJ; k++) begin
            objs[k].et  = obj_et_i[k*ET_W +: ET_W];
            objs[k].eta = obj_eta_i[k*ETA_W +: ETA_W];
            objs[k].phi = obj_phi_i[k*PHI_W +: PHI_W];
            objs[k].iso = obj_iso_i[k];
        end
        cfg_l1.thr      = l1_thr_i;
        cfg_l1.eta_lo   = l1_eta_lo_i;
        cfg_l1.eta_hi   = l1_eta_hi_i;
        cfg_l1.phi_lo   = l1_phi_lo_i;
        cfg_l1.phi_hi   = l1_phi_hi_i;
        cfg_l1.iso_req  = l1_iso_req_i;
        cfg_l2.thr      = l2_thr_i;
        cfg_l2.eta_lo   = l2_eta_lo_i;
        cfg_l2.eta_hi   = l2_eta_hi_i;
        cfg_l2.phi_lo   = l2_phi_lo_i;
        cfg_l2.phi_hi   = l2_phi_hi_i;
        cfg_l2.iso_req  = l2_iso_req_i;
        cfg_corr.deta_min = deta_min_i;
        cfg_corr.deta_max = deta_max_i;
        cfg_corr.dphi_min = dphi_min_i;
        cfg_corr.dphi_max = dphi_max_i;
    end

    // per-object leg selection, both legs
    for (genvar k = 0; k < N_OBJ; k++) begin : g_obj
        pcc_leg_sel u_leg1 (.obj(objs[k]), .cfg(cfg_l1), .pass(pass_l1[k]));
        pcc_leg_sel u_leg2 (.obj(objs[k]), .cfg(cfg_l2), .pass(pass_l2[k]));
    end

    // pair geometry for every ordered pair; diagonal forced off (distinct objects)
    for (genvar a = 0; a < N_OBJ; a++) begin : g_a
        for (genvar b = 0; b < N_OBJ; b++) begin : g_b
            if (a != b) begin : g_pair
                pcc_pair_geom #(.PHI_BINS(PHI_BINS)) u_geom (
                    .obj_a(objs[a]),
                    .obj_b(objs[b]),
                    .cfg  (cfg_corr),
                    .ok   (geo_ok[a*N_OBJ+b])
                );
            end else begin : g_self
                assign geo_ok[a*N_OBJ+b] = 1'b0;
            end
        end
    end

    always_comb begin
        st_d        = st_q;
        // stage 1: per-object and per-pair flags, missing energy
        st_d.leg1   = pass_l1;
        st_d.leg2   = pass_l2;
        st_d.geo    = geo_ok;
        st_d.met_s1 = (met_i >= met_thr_i);
        // stage 2: OR over all ordered pairs
        st_d.pair   = 1'b0;
        for (int a = 0; a < N_OBJ; a++) begin
            for (int b = 0; b < N_OBJ; b++) begin
                if (st_q.leg1[a] && st_q.leg2[b] && st_q.geo[a*N_OBJ+b]) begin
                    st_d.pair = 1'b1;
                end
            end
        end
        st_d.met    = st_q.met_s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pair_hit_o = st_q.pair;
    assign met_hit_o  = st_q.met;

endmodule

// File: rtl/pcc_checks.sv
module pcc_checks
    import pcc_pkg::*;
#(
    parameter int N_OBJ = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N_OBJ*ET_W-1:0] obj_et_i,
    input logic [MET_W-1:0]      met_i,
    input logic [MET_W-1:0]      met_thr_i,
    input logic                  pair_hit_o,
    input logic                  met_hit_o
);
    logic [1:0]       cyc_q;
    logic [N_OBJ-1:0] nz;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= 2'd0;
        end else if (cyc_q != 2'd2) begin
            cyc_q <= cyc_q + 2'd1;
        end
    end

    always_comb begin
        for (int k = 0; k < N_OBJ; k++) begin
            nz[k] = |obj_et_i[k*ET_W +: ET_W];
        end
    end

    // R1 with R7 latency
    p_met_compare_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd2) |-> (met_hit_o == ($past(met_i, 2) >= $past(met_thr_i, 2))));

    // R8
    p_reset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q != 2'd2) |-> (!pair_hit_o && !met_hit_o));

    // R3
    p_two_objects_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc_q == 2'd2) && ($countones($past(nz, 2)) < 2)) |-> !pair_hit_o);

    // R9
    p_all_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc_q == 2'd2) && ($past(nz, 2) == '0)) |-> !pair_hit_o);

endmodule

bind pair_corr_cond pcc_checks #(.N_OBJ(N_OBJ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .obj_et_i  (obj_et_i),
    .met_i     (met_i),
    .met_thr_i (met_thr_i),
    .pair_hit_o(pair_hit_o),
    .met_hit_o (met_hit_o)
);

// File: tb/pair_corr_cond_test.sv
module pair_corr_cond_test;
    import pcc_pkg::*;

    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [ET_W-1:0]         b_et  [N];
    logic signed [ETA_W-1:0] b_eta [N];
    logic [PHI_W-1:0]        b_phi [N];
    logic [N-1:0]            b_iso;
    logic [MET_W-1:0]        met, met_thr;
    logic [ET_W-1:0]         t1, t2;
    logic signed [ETA_W-1:0] e1lo, e1hi, e2lo, e2hi;
    logic [PHI_W-1:0]        p1lo, p1hi, p2lo, p2hi;
    logic                    i1, i2;
    logic [DETA_W-1:0]       demin, demax;
    logic [PHI_W-1:0]        dpmin, dpmax;

    logic [N*ET_W-1:0]  et_bus;
    logic [N*ETA_W-1:0] eta_bus;
    logic [N*PHI_W-1:0] phi_bus;
    logic               pair_hit, met_hit;

    always_comb begin
        for (int k = 0; k < N; k++) begin
            et_bus[k*ET_W +: ET_W]    = b_et[k];
            eta_bus[k*ETA_W +: ETA_W] = b_eta[k];
            phi_bus[k*PHI_W +: PHI_W] = b_phi[k];
        end
    end

    pair_corr_cond uut (
        .clk(clk), .rst_n(rst_n),
        .obj_et_i(et_bus), .obj_eta_i(eta_bus), .obj_phi_i(phi_bus), .obj_iso_i(b_iso),
        .met_i(met), .met_thr_i(met_thr),
        .l1_thr_i(t1), .l1_eta_lo_i(e1lo), .l1_eta_hi_i(e1hi),
        .l1_phi_lo_i(p1lo), .l1_phi_hi_i(p1hi), .l1_iso_req_i(i1),
        .l2_thr_i(t2), .l2_eta_lo_i(e2lo), .l2_eta_hi_i(e2hi),
        .l2_phi_lo_i(p2lo), .l2_phi_hi_i(p2hi), .l2_iso_req_i(i2),
        .deta_min_i(demin), .deta_max_i(demax), .dphi_min_i(dpmin), .dphi_max_i(dpmax),
        .pair_hit_o(pair_hit), .met_hit_o(met_hit)
    );

    int n_tests = 0;
    int n_fail  = 0;

    bit    ep [2];
    bit    em [2];
    bit    vq [2];
    string tq [2];

    task automatic chk(input bit act, input bit exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    // R2 model
    function automatic bit leg_ok(int k, int leg);
        int e, th, lo, hi, pl, ph;
        bit ir;
        e  = int'(b_eta[k]);
        th = (leg == 1) ? int'(t1) : int'(t2);
        lo = (leg == 1) ? int'(e1lo) : int'(e2lo);
        hi = (leg == 1) ? int'(e1hi) : int'(e2hi);
        pl = (leg == 1) ? int'(p1lo) : int'(p2lo);
        ph = (leg == 1) ? int'(p1hi) : int'(p2hi);
        ir = (leg == 1) ? i1 : i2;
        if (int'(b_et[k]) == 0) return 1'b0;
        if (int'(b_et[k]) < th) return 1'b0;
        if (e < lo || e > hi) return 1'b0;
        if (int'(b_phi[k]) < pl || int'(b_phi[k]) > ph) return 1'b0;
        if (ir && !b_iso[k]) return 1'b0;
        return 1'b1;
    endfunction

    // R5, R6 model
    function automatic bit corr_ok(int a, int b);
        int de, dp;
        de = int'(b_eta[a]) - int'(b_eta[b]);
        if (de < 0) de = -de;
        dp = int'(b_phi[a]) - int'(b_phi[b]);
        if (dp < 0) dp = -dp;
        if (dp > 36) dp = 72 - dp;
        return (de >= int'(demin)) && (de <= int'(demax)) &&
               (dp >= int'(dpmin)) && (dp <= int'(dpmax));
    endfunction

    function automatic bit model_pair();
        bit hit = 1'b0;
        for (int a = 0; a < N; a++)
            for (int b = 0; b < N; b++)
                if (a != b && leg_ok(a, 1) && leg_ok(b, 2) && corr_ok(a, b)) hit = 1'b1;
        return hit;
    endfunction

    // inputs set at a falling edge; result checked two falling edges later (R7)
    task automatic step(input string tag);
        ep[1] = ep[0]; em[1] = em[0]; vq[1] = vq[0]; tq[1] = tq[0];
        ep[0] = model_pair();
        em[0] = (met >= met_thr);
        vq[0] = 1'b1;
        tq[0] = tag;
        @(negedge clk);
        if (vq[1]) begin
            chk(pair_hit, ep[1], {tq[1], " pair_hit"});
            chk(met_hit, em[1], {tq[1], " met_hit R1"});
        end
    endtask

    task automatic open_cfg();
        t1 = 10'd1; t2 = 10'd1;
        e1lo = -6'sd32; e1hi = 6'sd31; e2lo = -6'sd32; e2hi = 6'sd31;
        p1lo = '0; p1hi = '1; p2lo = '0; p2hi = '1;
        i1 = 1'b0; i2 = 1'b0;
        demin = '0; demax = '1; dpmin = '0; dpmax = '1;
        met = '0; met_thr = '1;
    endtask

    task automatic clear_objs();
        for (int k = 0; k < N; k++) begin
            b_et[k] = '0; b_eta[k] = '0; b_phi[k] = '0;
        end
        b_iso = '0;
    endtask

    function automatic logic [PHI_W-1:0] rnd_phi();
        case ($urandom_range(0, 9))
            0: return 7'd0;
            1: return 7'd1;
            2: return 7'd35;
            3: return 7'd36;
            4: return 7'd37;
            5: return 7'd70;
            6: return 7'd71;
            default: return PHI_W'($urandom_range(0, 71));
        endcase
    endfunction

    task automatic rnd_cfg();
        t1   = ET_W'($urandom_range(0, 12));
        t2   = ET_W'($urandom_range(0, 12));
        e1lo = ETA_W'(int'($urandom_range(0, 8)) - 8);
        e1hi = ETA_W'($urandom_range(0, 8));
        e2lo = ETA_W'(int'($urandom_range(0, 8)) - 8);
        e2hi = ETA_W'($urandom_range(0, 8));
        p1lo = PHI_W'($urandom_range(0, 36));
        p1hi = PHI_W'($urandom_range(30, 71));
        p2lo = PHI_W'($urandom_range(0, 36));
        p2hi = PHI_W'($urandom_range(30, 71));
        i1   = ($urandom_range(0, 3) == 0);
        i2   = ($urandom_range(0, 3) == 0);
        demin = DETA_W'($urandom_range(0, 3));
        demax = DETA_W'($urandom_range(2, 16));
        dpmin = PHI_W'($urandom_range(0, 4));
        dpmax = PHI_W'($urandom_range(3, 40));
        met_thr = MET_W'($urandom_range(0, 63));
    endtask

    task automatic rnd_objs();
        for (int k = 0; k < N; k++) begin
            b_et[k]  = ($urandom_range(0, 3) == 0) ? '0 : ET_W'($urandom_range(0, 20));
            b_eta[k] = ETA_W'(int'($urandom_range(0, 15)) - 8);
            b_phi[k] = rnd_phi();
        end
        b_iso = N'($urandom_range(0, 15));
        met   = MET_W'($urandom_range(0, 63));
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R7: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        vq[0] = 1'b0; vq[1] = 1'b0; ep = '{0, 0}; em = '{0, 0};
        open_cfg();
        clear_objs();
        // a hitting crossing held during reset
        b_et[0] = 10'd5; b_et[1] = 10'd5; b_phi[1] = 7'd3;
        met = 12'd9; met_thr = 12'd1;
        repeat (3) @(negedge clk);
        chk(pair_hit, 1'b0, "R8 reset pair");
        chk(met_hit, 1'b0, "R8 reset met");
        rst_n = 1'b1;
        @(negedge clk);
        chk(pair_hit, 1'b0, "R8 first edge after release");
        chk(met_hit, 1'b0, "R8 first edge after release met");
        step("R8 R7 first crossing");

        // R1 boundary
        open_cfg(); clear_objs();
        met = 12'd40; met_thr = 12'd40; step("R1 equal");
        met = 12'd39; step("R1 below");
        met = 12'hFFF; met_thr = 12'd0; step("R1 max");

        // R2 threshold boundary
        open_cfg(); clear_objs();
        t1 = 10'd7; t2 = 10'd7;
        b_et[0] = 10'd7; b_et[1] = 10'd7; b_phi[1] = 7'd10; step("R2 at threshold");
        b_et[1] = 10'd6; step("R2 below threshold");
        // R2 isolation
        b_et[1] = 10'd7; i1 = 1'b1; b_iso = '0; step("R2 isolation missing");
        b_iso = 4'b0010; step("R2 isolation on obj1");
        // R2 signed eta window
        open_cfg(); clear_objs();
        e1lo = -6'sd4; e1hi = -6'sd2; e2lo = -6'sd4; e2hi = -6'sd2;
        b_et[0] = 10'd3; b_et[1] = 10'd3; b_eta[0] = -6'sd4; b_eta[1] = -6'sd2; step("R2 eta edges");
        b_eta[1] = -6'sd1; step("R2 eta outside");

        // R3 one object passing both legs
        open_cfg(); clear_objs();
        b_et[2] = 10'd30; step("R3 single object");
        b_et[3] = 10'd1; t2 = 10'd5; step("R3 second object fails leg2");

        // R9 zero energy with zero threshold
        open_cfg(); clear_objs();
        t1 = '0; t2 = '0; b_et[1] = 10'd4; step("R9 zero energy empty");

        // R4 and R10: leg1 only on obj3, leg2 only on obj0
        open_cfg(); clear_objs();
        t1 = 10'd50; t2 = 10'd1; p2hi = 7'd20;
        b_et[3] = 10'd60; b_phi[3] = 7'd40;
        b_et[0] = 10'd2;  b_phi[0] = 7'd5;
        step("R4 R10 reversed order");
        b_phi[0] = 7'd21; step("R4 leg2 outside window");

        // R6 wrap-around
        open_cfg(); clear_objs();
        b_et[0] = 10'd5; b_et[1] = 10'd5; b_phi[0] = 7'd71; b_phi[1] = 7'd1;
        dpmin = 7'd2; dpmax = 7'd2; step("R6 wrap distance 2");
        dpmin = 7'd0; dpmax = 7'd1; step("R6 wrap below range");
        b_phi[0] = 7'd36; b_phi[1] = 7'd0; dpmin = 7'd36; dpmax = 7'd36; step("R6 half ring");

        // R5 eta separation
        open_cfg(); clear_objs();
        b_et[0] = 10'd5; b_et[1] = 10'd5; b_eta[0] = -6'sd5; b_eta[1] = 6'sd5;
        demin = 7'd10; demax = 7'd10; step("R5 separation 10");
        demin = 7'd0; demax = 7'd9; step("R5 separation above max");

        // streaming sweep with the model (R2 R4 R5 R6 R7)
        for (int n = 0; n < 4000; n++) begin
            if (n % 40 == 0) rnd_cfg();
            rnd_objs();
            step("R2 R4 R5 R6 R7 sweep");
        end
        step("R7 flush");
        step("R7 flush");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule